// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two operands written in redundant binary signed-digit form and returns their sum in the same form. Each digit is -1, 0 or +1 and travels on two wires, an up rail and a down rail. The block is purely combinational. It is a row of identical per-position cells, and each cell looks only at its own two operand digits and at two small signals from the position just below. No carry chain runs the length of the word, so the depth of the logic stays the same at any width.

Each position first splits its digit sum into an interim digit and a transfer to the next position. It picks between the two possible splits with a one-bit flag from the position below. That flag says whether either lower operand digit is +1. The chosen split guarantees that interim digit plus incoming transfer never leaves {-1, 0, +1}. The result has one more digit than the operands, and that top digit is the transfer out of the highest position. The block suits wide accumulations and multiplier partial-product trees that keep their values redundant until a final conversion elsewhere.

Top module: `sdadd_top`

## Requirements
- R1: Every operand and result digit is a rail pair (up, down) with +1 = (1,0), 0 = (0,0) and -1 = (0,1); (1,1) is illegal on the inputs and is never driven. Operands have WIDTH digits and the result has WIDTH+1. Digit i weighs 2^i.
- R2: For any legal operands, the value of the result equals the sum of the operand values exactly, at every width (exercised at 8, 16 and 64 digits).
- R3: No result digit ever has both rails set.
- R4: A position whose digit sum is +1 or -1 chooses its split from the lower flag. If either lower operand digit is +1, it emits interim -1, with transfer +1 for a sum of +1 and transfer 0 for a sum of -1. Otherwise it emits interim +1, with transfer 0 for a sum of +1 and transfer -1 for a sum of -1. Position 0 sees the flag clear and no incoming transfer. So +1 alone at digit 0 gives result digit 0 = +1 and nothing else. -1 alone at digit 0 gives digit 1 = -1 and digit 0 = +1. +1 at digits 0 and 1 of one operand gives digits 2..0 = (+1, -1, +1).
- R5: The extra top result digit is +1 when both top operand digits are +1, -1 when both are -1, and 0 when they cancel.
- R6: When every operand digit pair cancels (b is a negated digit by digit), all result digits are 0.
- R7: Changing the operand digits at position k can change only result digits k, k+1 and k+2. All other result digits stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_up | input | WIDTH | Up rails of operand A |
| a_dn | input | WIDTH | Down rails of operand A |
| b_up | input | WIDTH | Up rails of operand B |
| b_dn | input | WIDTH | Down rails of operand B |
| sum_up | output | WIDTH+1 | Up rails of the result |
| sum_dn | output | WIDTH+1 | Down rails of the result |

## Verification
The bench drives the split-selection corners directly: a lone +1 or -1 at the lowest digit, and a run of +1 digits that forces an interim -1 to meet an incoming +1. A cell with the flag polarity reversed would produce an out-of-range sum there, and it would show as a wrong value or a digit with both rails set. The top digit is checked for both-positive, both-negative and cancelling top pairs, which catches a top digit that is dropped or wired from the wrong rail. The bench also flips one digit and checks that results more than two places above it do not move, which exposes any dependence that reaches too far. Digit-wise cancelling operands must give an all-zero result, so a design that leaves a stray transfer behind fails there.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } sdigit_t;

  localparam sdigit_t SD_ZERO = '{up: 1'b0, dn: 1'b0};

  function automatic logic sd_nonzero(input sdigit_t d);
    return d.up ^ d.dn;
  endfunction

endpackage

// File: rtl/sdadd_split_cell.sv
module sdadd_split_cell
  import sdadd_pkg::*;
(
  input  sdigit_t op_a,
  input  sdigit_t op_b,
  input  logic    lower_pos,
  output logic    odd_sum,
  output logic    here_pos,
  output sdigit_t xfer_out
);

  logic pair_up, pair_dn, lone_up, lone_dn;

  always_comb begin
    pair_up  = op_a.up & op_b.up;
    pair_dn  = op_a.dn & op_b.dn;
    lone_up  = (op_a.up & ~sd_nonzero(op_b)) | (op_b.up & ~sd_nonzero(op_a));
    lone_dn  = (op_a.dn & ~sd_nonzero(op_b)) | (op_b.dn & ~sd_nonzero(op_a));
    odd_sum  = sd_nonzero(op_a) ^ sd_nonzero(op_b);
    here_pos = op_a.up | op_b.up;
    xfer_out.up = pair_up | (lone_up & lower_pos);
    xfer_out.dn = pair_dn | (lone_dn & ~lower_pos);
  end

endmodule

// File: rtl/sdadd_merge_cell.sv
module sdadd_merge_cell
  import sdadd_pkg::*;
(
  input  logic    odd_sum,
  input  logic    lower_pos,
  input  sdigit_t xfer_in,
  input  logic    chk_en,
  output sdigit_t sum_d
);

  always_comb begin
    if (odd_sum) begin
      sum_d.up = ~lower_pos & ~xfer_in.dn;
      sum_d.dn = lower_pos & ~xfer_in.up;
    end else begin
      sum_d = xfer_in;
    end
  end

  always_comb begin
    if (chk_en) begin
      // R4
      xfer_sign_chk: assert (!(lower_pos && xfer_in.dn) && !(!lower_pos && xfer_in.up))
        else $error("transfer sign disagrees with lower positive flag");
      // R3
      rail_excl_chk: assert (!(sum_d.up && sum_d.dn))
        else $error("result digit has both rails set");
    end
  end

endmodule

// File: rtl/sdadd_top.sv
module sdadd_top
  import sdadd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_up,
  input  logic [WIDTH-1:0] a_dn,
  input  logic [WIDTH-1:0] b_up,
  input  logic [WIDTH-1:0] b_dn,
  output logic [WIDTH:0]   sum_up,
  output logic [WIDTH:0]   sum_dn
);

  localparam int OUT_W = WIDTH + 1;

  logic    [WIDTH:0]   pos_chain;
  sdigit_t [WIDTH:0]   xfer_chain;
  logic    [WIDTH-1:0] odd_vec;
  sdigit_t [OUT_W-1:0] res_d;
  logic                ops_legal;

  assign ops_legal     = ~|(a_up & a_dn) & ~|(b_up & b_dn);
  assign pos_chain[0]  = 1'b0;
  assign xfer_chain[0] = SD_ZERO;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    sdigit_t dig_a, dig_b;
    assign dig_a = '{up: a_up[i], dn: a_dn[i]};
    assign dig_b = '{up: b_up[i], dn: b_dn[i]};

    sdadd_split_cell u_split (
      .op_a      (dig_a),
      .op_b      (dig_b),
      .lower_pos (pos_chain[i]),
      .odd_sum   (odd_vec[i]),
      .here_pos  (pos_chain[i+1]),
      .xfer_out  (xfer_chain[i+1])
    );

    sdadd_merge_cell u_merge (
      .odd_sum   (odd_vec[i]),
      .lower_pos (pos_chain[i]),
      .xfer_in   (xfer_chain[i]),
      .chk_en    (ops_legal),
      .sum_d     (res_d[i])
    );
  end

  assign res_d[OUT_W-1] = xfer_chain[WIDTH];

  for (genvar j = 0; j < OUT_W; j++) begin : g_out
    assign sum_up[j] = res_d[j].up;
    assign sum_dn[j] = res_d[j].dn;
  end

  always_comb begin
    if (ops_legal) begin
      // R5
      top_digit_chk: assert ((!(a_up[WIDTH-1] && b_up[WIDTH-1]) || (sum_up[WIDTH] && !sum_dn[WIDTH])) &&
                             (!(a_dn[WIDTH-1] && b_dn[WIDTH-1]) || (sum_dn[WIDTH] && !sum_up[WIDTH])))
        else $error("top result digit wrong for matched top operands");
      // R6
      cancel_zero_chk: assert (!(a_up == b_dn && a_dn == b_up) || (sum_up == '0 && sum_dn == '0))
        else $error("cancelling operands left a nonzero digit");
    end
  end

endmodule

// File: tb/sdadd_top_tb.sv
module sdadd_top_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0]  a8_up, a8_dn, b8_up, b8_dn;
  logic [8:0]  s8_up, s8_dn;
  logic [15:0] a16_up, a16_dn, b16_up, b16_dn;
  logic [16:0] s16_up, s16_dn;
  logic [63:0] a64_up, a64_dn, b64_up, b64_dn;
  logic [64:0] s64_up, s64_dn;

  sdadd_top #(.WIDTH(8)) u_dut_w8 (
    .a_up(a8_up), .a_dn(a8_dn), .b_up(b8_up), .b_dn(b8_dn),
    .sum_up(s8_up), .sum_dn(s8_dn));

  sdadd_top #(.WIDTH(16)) u_dut (
    .a_up(a16_up), .a_dn(a16_dn), .b_up(b16_up), .b_dn(b16_dn),
    .sum_up(s16_up), .sum_dn(s16_dn));

  sdadd_top #(.WIDTH(64)) u_dut_w64 (
    .a_up(a64_up), .a_dn(a64_dn), .b_up(b64_up), .b_dn(b64_dn),
    .sum_up(s64_up), .sum_dn(s64_dn));

  function automatic logic signed [71:0] sd_value(input logic [64:0] up, input logic [64:0] dn, input int cnt);
    logic signed [71:0] acc;
    acc = '0;
    for (int i = cnt - 1; i >= 0; i--) begin
      acc = acc * 2;
      if (up[i]) acc = acc + 1;
      if (dn[i]) acc = acc - 1;
    end
    return acc;
  endfunction

  task automatic check_num(input string req, input logic signed [71:0] act, input logic signed [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rand_op(input int w, output logic [63:0] up, output logic [63:0] dn);
    up = '0;
    dn = '0;
    for (int i = 0; i < w; i++) begin
      case ($urandom % 3)
        1: up[i] = 1'b1;
        2: dn[i] = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic apply(input int w, input logic [63:0] au, input logic [63:0] ad,
                       input logic [63:0] bu, input logic [63:0] bd,
                       output logic [64:0] su, output logic [64:0] sd);
    @(negedge clk);
    a8_up  = au[7:0];  a8_dn  = ad[7:0];  b8_up  = bu[7:0];  b8_dn  = bd[7:0];
    a16_up = au[15:0]; a16_dn = ad[15:0]; b16_up = bu[15:0]; b16_dn = bd[15:0];
    a64_up = au;       a64_dn = ad;       b64_up = bu;       b64_dn = bd;
    @(posedge clk);
    #(CLK_PERIOD/4);
    su = '0;
    sd = '0;
    case (w)
      8:  begin su[8:0]  = s8_up;  sd[8:0]  = s8_dn;  end
      16: begin su[16:0] = s16_up; sd[16:0] = s16_dn; end
      default: begin su = s64_up; sd = s64_dn; end
    endcase
  endtask

  task automatic add_and_check(input string req, input int w, input logic [63:0] au, input logic [63:0] ad,
                               input logic [63:0] bu, input logic [63:0] bd);
    logic [64:0] su, sd;
    apply(w, au, ad, bu, bd, su, sd);
    check_num(req, sd_value(su, sd, w + 1),
              sd_value({1'b0, au}, {1'b0, ad}, w) + sd_value({1'b0, bu}, {1'b0, bd}, w));
    check_vec({req, " R3 rails"}, su & sd, '0);
  endtask

  // R6: all-zero operands and digit-wise cancelling operands give all-zero digits
  task automatic t_cancel();
    logic [64:0] su, sd;
    logic [63:0] au, ad;
    apply(16, '0, '0, '0, '0, su, sd);
    check_vec("R6 zero up", su, '0);
    check_vec("R6 zero dn", sd, '0);
    for (int k = 0; k < 20; k++) begin
      rand_op(64, au, ad);
      apply(64, au, ad, ad, au, su, sd);
      check_vec("R6 cancel", su | sd, '0);
    end
  endtask

  // R4: split selection at the lowest digits, exact digit patterns (R1 encoding)
  task automatic t_split();
    logic [64:0] su, sd;
    apply(16, 64'h1, '0, '0, '0, su, sd);
    check_vec("R4 plus one up", su, 65'h1);
    check_vec("R4 plus one dn", sd, 65'h0);
    apply(16, '0, 64'h1, '0, '0, su, sd);
    check_vec("R4 minus one up", su, 65'h1);
    check_vec("R4 minus one dn", sd, 65'h2);
    apply(16, 64'h3, '0, '0, '0, su, sd);
    check_vec("R4 three up", su, 65'h5);
    check_vec("R4 three dn", sd, 65'h2);
    apply(8, 64'h1, '0, 64'h1, '0, su, sd);
    check_vec("R4 one plus one up", su, 65'h2);
    check_vec("R4 one plus one dn", sd, 65'h0);
  endtask

  // R5: extra top digit at each width
  task automatic t_top();
    logic [64:0] su, sd;
    int ws [3] = '{8, 16, 64};
    foreach (ws[n]) begin
      int w;
      logic [63:0] full;
      w = ws[n];
      full = (w == 64) ? '1 : ((64'h1 << w) - 1);
      apply(w, full, '0, full, '0, su, sd);
      check_vec("R5 both plus", {63'b0, su[w], sd[w]}, 65'h2);
      check_num("R5 R2 max sum", sd_value(su, sd, w + 1),
                sd_value({1'b0, full}, 65'b0, w) * 2);
      apply(w, '0, full, '0, full, su, sd);
      check_vec("R5 both minus", {63'b0, su[w], sd[w]}, 65'h1);
      check_num("R5 R2 min sum", sd_value(su, sd, w + 1),
                -(sd_value({1'b0, full}, 65'b0, w) * 2));
      apply(w, full, '0, '0, full, su, sd);
      check_vec("R5 top cancels", {63'b0, su[w], sd[w]}, 65'h0);
    end
  endtask

  // R2 R3: random legal operands at three widths
  task automatic t_random();
    logic [63:0] au, ad, bu, bd;
    int ws [3] = '{8, 16, 64};
    foreach (ws[n]) begin
      for (int k = 0; k < 150; k++) begin
        rand_op(ws[n], au, ad);
        rand_op(ws[n], bu, bd);
        add_and_check("R2 random", ws[n], au, ad, bu, bd);
      end
    end
  endtask

  // R7: a digit change at position k disturbs only result digits k..k+2
  task automatic t_local();
    logic [63:0] au, ad, bu, bd, au2, ad2;
    logic [64:0] su0, sd0, su1, sd1, keep;
    for (int k = 0; k < 40; k++) begin
      int pos;
      pos = $urandom % 16;
      rand_op(16, au, ad);
      rand_op(16, bu, bd);
      apply(16, au, ad, bu, bd, su0, sd0);
      au2 = au;
      ad2 = ad;
      if (au[pos]) begin
        au2[pos] = 1'b0; ad2[pos] = 1'b1;
      end else if (ad[pos]) begin
        ad2[pos] = 1'b0;
      end else begin
        au2[pos] = 1'b1;
      end
      apply(16, au2, ad2, bu, bd, su1, sd1);
      keep = '0;
      for (int j = 0; j < 17; j++) keep[j] = (j < pos) || (j > pos + 2);
      check_vec("R7 locality up", su1 & keep, su0 & keep);
      check_vec("R7 locality dn", sd1 & keep, sd0 & keep);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    a8_up = '0; a8_dn = '0; b8_up = '0; b8_dn = '0;
    a16_up = '0; a16_dn = '0; b16_up = '0; b16_dn = '0;
    a64_up = '0; a64_dn = '0; b64_up = '0; b64_dn = '0;
    t_cancel();
    t_split();
    t_top();
    t_random();
    t_local();
    finish_run();
  end

endmodule